// File: doc/BRIEF.md
# Two-Group Interrupt Routing Controller

This block gathers two groups of sixteen level-sensitive interrupt sources and steers each enabled, pending source to one of five processor interrupt lines. Software enables sources through one mask register per group. It picks the destination line for each routable source by writing 3-bit selector fields, which are packed several to a 16-bit register. A source takes part only while its input is high and its mask bit is set. A line stays raised for as long as at least one such source is routed to it.

For each line the block also keeps a vector register naming the one source behind it. The handler reads this register to find the cause without scanning the pending bits itself. The search gives precedence to the first group over the second, and within a group to the lower pin number. When nothing is routed to a line, the vector reads zero, and software treats that as a spurious request. All registers are reached through a single-cycle 16-bit read/write port with two address windows. Read data is combinational from the address, and writes take effect at the clock edge.

Top module: `irq_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, both masks clear to 0x0000, all interrupt lines drop to 0 and all vectors clear to 0. The four selector registers (window 0 offsets 0x04, 0x06, 0x1C, 0x1E) return to 0x0040, 0x0000, 0x0002 and 0x0000.
- R2: Reading offset 0x00 returns the live group-A inputs in window 0 (`reg_win`=0) and the live group-B inputs in window 1. Writes to offset 0x00 in either window have no effect.
- R3: The group-A mask is at window 0 offset 0x0C and the group-B mask is at window 1 offset 0x06. Both are 16 bits wide and every bit can be written and read back.
- R4: A source is active when its input bit and its mask bit are both 1. Line o is high one clock edge after some active source's selector equals o, and it drops one edge after the last such source loses its input or mask bit. A mask write itself lands at its own edge, so its effect on the lines appears at the edge after that.
- R5: Selector fields are 3 bits wide, at bit positions 0, 3, 6, 9 and 12. The register at 0x04 holds group-A pins 0, 1, 2, 3 and 8 in that slot order. The register at 0x06 holds group-A pin 9 at bit 0, pin 11 at bit 6 and pin 12 at bit 9. The register at 0x1C holds group-B pins 0, 1, 3, 4 and 5. The register at 0x1E holds group-B pins 6 to 10.
- R6: In a selector write, a field value above 4 is discarded and that field keeps its old value. The other fields of the same write still update.
- R7: Bit 15 of every selector register, and bits 3 to 5 and 12 to 14 of the 0x06 register, ignore writes and read 0. Pins without a selector field are always routed to line 0.
- R8: Out of reset, every source routes to line 0 except group-A pin 2, which goes to line 1, and group-B pin 0, which goes to line 2.
- R9: The vector for line o is at window 1 offset 0x10+2*o. Bit 5 is valid, bit 4 is the group (0 = A) and bits 3:0 are the pin; all other bits are 0. The vector names the first active source routed to o, scanning group A from pin 0 upward and then group B, and it reads 0 when no source is routed there. It updates on the same edge as the line.
- R10: Offsets not listed above read 0 in each window, and writes to them, or to the vector offsets, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_a | input | 16 | Group-A interrupt sources, level-sensitive |
| src_b | input | 16 | Group-B interrupt sources, level-sensitive |
| reg_win | input | 1 | Register window select (0 = window 0, 1 = window 1) |
| reg_addr | input | 5 | Byte offset within the window |
| reg_we | input | 1 | Write strobe, taken at the clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the current window and offset |
| cpu_irq | output | 5 | Processor interrupt lines 0 to 4 |

## Verification
The hardest cases to reach are the precedence between many simultaneously active sources spread across differently programmed lines, and a selector write that mixes legal values, out-of-range values and reserved bits. To reach the precedence cases, the stimulus first sweeps every pin of both groups on its own under two full selector programs. It then runs a long pseudo-random phase that reprograms masks and selectors between bursts of random source patterns. Before that, directed writes with hand-built mixes of legal, oversized and reserved fields exercise the partial-update rule. Every line and vector read is compared with a model that the bench keeps from its own register writes.

// File: rtl/irq_router_pkg.sv
// Shared constants, types and pin-to-field map for the interrupt router.
// Assumes two source groups and selector fields packed five per register.
package irq_router_pkg;

    localparam int SRC_W       = 16;
    localparam int N_GRP       = 2;
    localparam int N_OUT       = 5;
    localparam int FLD_W       = 3;
    localparam int FLD_PER_REG = 5;
    localparam int N_ASG       = 4;
    localparam int ADDR_W      = 5;
    localparam int DATA_W      = 16;
    localparam int PIN_W       = $clog2(SRC_W);

    localparam logic [FLD_W-1:0] MAX_SEL = FLD_W'(N_OUT - 1);
    localparam logic [FLD_W-1:0] DEF_SEL = '0;

    localparam logic [ADDR_W-1:0] ADDR_PEND   = 5'h00;
    localparam logic [ADDR_W-1:0] ADDR_ASG0   = 5'h04;
    localparam logic [ADDR_W-1:0] ADDR_ASG1   = 5'h06;
    localparam logic [ADDR_W-1:0] ADDR_MASK_A = 5'h0C;
    localparam logic [ADDR_W-1:0] ADDR_ASG2   = 5'h1C;
    localparam logic [ADDR_W-1:0] ADDR_ASG3   = 5'h1E;
    localparam logic [ADDR_W-1:0] ADDR_MASK_B = 5'h06;
    localparam logic [ADDR_W-1:0] ADDR_VEC0   = 5'h10;

    // Writable bits per selector register (index 0 in the low word).
    localparam logic [N_ASG-1:0][DATA_W-1:0] ASG_LEGAL =
        {16'h7FFF, 16'h7FFF, 16'h0FC7, 16'h7FFF};
    // Reset image per selector register.
    localparam logic [N_ASG-1:0][DATA_W-1:0] ASG_RESET =
        {16'h0000, 16'h0002, 16'h0000, 16'h0040};

    typedef struct packed {
        logic             valid;
        logic             grp;
        logic [PIN_W-1:0] pin;
    } vec_t;

    typedef struct packed {
        logic       ok;
        logic [1:0] reg_idx;
        logic [2:0] slot;
    } slot_t;

    // Where a given group/pin keeps its selector, if anywhere.
    function automatic slot_t pin_slot(input int grp, input int pin);
        slot_t s;
        s = '0;
        if (grp == 0) begin
            case (pin)
                0, 1, 2, 3: begin s.ok = 1'b1; s.reg_idx = 2'd0; s.slot = 3'(pin); end
                8:          begin s.ok = 1'b1; s.reg_idx = 2'd0; s.slot = 3'd4; end
                9:          begin s.ok = 1'b1; s.reg_idx = 2'd1; s.slot = 3'd0; end
                11:         begin s.ok = 1'b1; s.reg_idx = 2'd1; s.slot = 3'd2; end
                12:         begin s.ok = 1'b1; s.reg_idx = 2'd1; s.slot = 3'd3; end
                default:    s = '0;
            endcase
        end else begin
            case (pin)
                0, 1:          begin s.ok = 1'b1; s.reg_idx = 2'd2; s.slot = 3'(pin); end
                3, 4, 5:       begin s.ok = 1'b1; s.reg_idx = 2'd2; s.slot = 3'(pin - 1); end
                6, 7, 8, 9, 10: begin s.ok = 1'b1; s.reg_idx = 2'd3; s.slot = 3'(pin - 6); end
                default:       s = '0;
            endcase
        end
        return s;
    endfunction

    // Window-0 offset of selector register r.
    function automatic logic [ADDR_W-1:0] asg_addr(input int r);
        case (r)
            0:       return ADDR_ASG0;
            1:       return ADDR_ASG1;
            2:       return ADDR_ASG2;
            default: return ADDR_ASG3;
        endcase
    endfunction

endpackage

// File: rtl/irq_router_regs.sv
// Register file of the interrupt router: two masks, four selector
// registers and the combinational read mux. Assumes single-cycle access;
// out-of-range selector values and reserved bits are dropped on write.
module irq_router_regs
    import irq_router_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_win,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic                          reg_we,
    input  logic [DATA_W-1:0]             reg_wdata,
    input  logic [SRC_W-1:0]              src_a,
    input  logic [SRC_W-1:0]              src_b,
    input  vec_t [N_OUT-1:0]              vec_q,
    output logic [SRC_W-1:0]              mask_a,
    output logic [SRC_W-1:0]              mask_b,
    output logic [N_ASG-1:0][DATA_W-1:0]  asg_q,
    output logic [DATA_W-1:0]             reg_rdata
);

    // Mask registers, one per group window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_a <= '0;
            mask_b <= '0;
        end else if (reg_we) begin
            if (!reg_win && reg_addr == ADDR_MASK_A) mask_a <= reg_wdata;
            if (reg_win && reg_addr == ADDR_MASK_B)  mask_b <= reg_wdata;
        end
    end

    // Selector registers: each legal field updates only with a value in range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asg_q <= ASG_RESET;
        end else if (reg_we && !reg_win) begin
            for (int r = 0; r < N_ASG; r++) begin
                for (int k = 0; k < FLD_PER_REG; k++) begin
                    if (reg_addr == asg_addr(r) &&
                        ASG_LEGAL[r][k*FLD_W] &&
                        reg_wdata[k*FLD_W +: FLD_W] <= MAX_SEL) begin
                        asg_q[r][k*FLD_W +: FLD_W] <= reg_wdata[k*FLD_W +: FLD_W];
                    end
                end
            end
        end
    end

    // Read mux across both windows; unknown offsets return zero.
    always_comb begin
        reg_rdata = '0;
        if (!reg_win) begin
            case (reg_addr)
                ADDR_PEND:   reg_rdata = src_a;
                ADDR_MASK_A: reg_rdata = mask_a;
                ADDR_ASG0:   reg_rdata = asg_q[0];
                ADDR_ASG1:   reg_rdata = asg_q[1];
                ADDR_ASG2:   reg_rdata = asg_q[2];
                ADDR_ASG3:   reg_rdata = asg_q[3];
                default:     reg_rdata = '0;
            endcase
        end else begin
            if (reg_addr == ADDR_PEND)   reg_rdata = src_b;
            if (reg_addr == ADDR_MASK_B) reg_rdata = mask_b;
            for (int o = 0; o < N_OUT; o++) begin
                if (reg_addr == ADDR_W'(ADDR_VEC0 + 2 * o))
                    reg_rdata = DATA_W'(vec_q[o]);
            end
        end
    end

endmodule

// File: rtl/irq_router_route.sv
// Combinational routing matrix: masks the sources, looks up each pin's
// selector and picks, per output line, the first active source in fixed
// order (group A before B, low pin first). Assumes selectors are in range.
module irq_router_route
    import irq_router_pkg::*;
(
    input  logic [SRC_W-1:0]              src_a,
    input  logic [SRC_W-1:0]              src_b,
    input  logic [SRC_W-1:0]              mask_a,
    input  logic [SRC_W-1:0]              mask_b,
    input  logic [N_ASG-1:0][DATA_W-1:0]  asg_q,
    output logic [N_OUT-1:0]              req,
    output vec_t [N_OUT-1:0]              vec
);

    logic [N_GRP-1:0][SRC_W-1:0]              act;
    wire  [N_GRP-1:0][SRC_W-1:0][FLD_W-1:0]   sel;

    // Active sources: input level qualified by the mask.
    always_comb begin
        act[0] = src_a & mask_a;
        act[1] = src_b & mask_b;
    end

    // Per-pin selector lookup; pins without a field sit on the default line.
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        for (genvar p = 0; p < SRC_W; p++) begin : g_pin
            localparam slot_t S = pin_slot(g, p);
            if (S.ok) begin : g_map
                assign sel[g][p] = asg_q[S.reg_idx][S.slot*FLD_W +: FLD_W];
            end else begin : g_fix
                assign sel[g][p] = DEF_SEL;
            end
        end
    end

    // Fixed-order winner search for every output line.
    always_comb begin
        req = '0;
        vec = '0;
        for (int o = 0; o < N_OUT; o++) begin
            for (int g = 0; g < N_GRP; g++) begin
                for (int p = 0; p < SRC_W; p++) begin
                    if (!req[o] && act[g][p] && sel[g][p] == FLD_W'(o)) begin
                        req[o]       = 1'b1;
                        vec[o].valid = 1'b1;
                        vec[o].grp   = 1'(g);
                        vec[o].pin   = PIN_W'(p);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/irq_router.sv
// Top of the two-group interrupt router. Registers the output lines and
// the per-line vectors one edge after sources, masks or selectors change.
// Assumes sources are synchronous to clk.
module irq_router
    import irq_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       src_a,
    input  logic [15:0]       src_b,
    input  logic              reg_win,
    input  logic [4:0]        reg_addr,
    input  logic              reg_we,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic [4:0]        cpu_irq
);

    logic [SRC_W-1:0]             mask_a;
    logic [SRC_W-1:0]             mask_b;
    logic [N_ASG-1:0][DATA_W-1:0] asg_q;
    logic [N_OUT-1:0]             req_d;
    vec_t [N_OUT-1:0]             vec_d;
    vec_t [N_OUT-1:0]             vec_q;
    logic [N_OUT-1:0]             irq_q;

    irq_router_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_win   (reg_win),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .src_a     (src_a),
        .src_b     (src_b),
        .vec_q     (vec_q),
        .mask_a    (mask_a),
        .mask_b    (mask_b),
        .asg_q     (asg_q),
        .reg_rdata (reg_rdata)
    );

    irq_router_route u_route (
        .src_a  (src_a),
        .src_b  (src_b),
        .mask_a (mask_a),
        .mask_b (mask_b),
        .asg_q  (asg_q),
        .req    (req_d),
        .vec    (vec_d)
    );

    // Output stage: lines and vectors move together on one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
            vec_q <= '0;
        end else begin
            irq_q <= req_d;
            vec_q <= vec_d;
        end
    end

    assign cpu_irq = irq_q;

endmodule

// File: rtl/irq_router_chk.sv
// Property checker for the interrupt router, observing its ports only.
// Assumes the clock and synchronous active-low reset of the top.
module irq_router_chk
    import irq_router_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] src_a,
    input logic [15:0] src_b,
    input logic        reg_win,
    input logic [4:0]  reg_addr,
    input logic [15:0] reg_rdata,
    input logic [4:0]  cpu_irq
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> cpu_irq == '0);

    // R4
    idle_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_a) == '0 && $past(src_b) == '0) |-> cpu_irq == '0);

    // R2
    pend_a_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_win && reg_addr == ADDR_PEND) |-> reg_rdata == src_a);

    // R2
    pend_b_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_win && reg_addr == ADDR_PEND) |-> reg_rdata == src_b);

    // R6
    sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_win && (reg_addr == ADDR_ASG0 || reg_addr == ADDR_ASG1 ||
                      reg_addr == ADDR_ASG2 || reg_addr == ADDR_ASG3))
        |-> (reg_rdata[2:0] <= 3'd4 && reg_rdata[5:3] <= 3'd4 &&
             reg_rdata[8:6] <= 3'd4 && reg_rdata[11:9] <= 3'd4 &&
             reg_rdata[14:12] <= 3'd4 && !reg_rdata[15]));

    // R7
    sel_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_win && reg_addr == ADDR_ASG1) |-> (reg_rdata & 16'hF038) == '0);

    for (genvar o = 0; o < N_OUT; o++) begin : g_vec
        // R9
        vec_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_win && reg_addr == 5'(ADDR_VEC0 + 2 * o))
            |-> (reg_rdata[5] == cpu_irq[o] && reg_rdata[15:6] == '0 &&
                 (reg_rdata[5] || reg_rdata == '0)));
    end

endmodule

bind irq_router irq_router_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_a     (src_a),
    .src_b     (src_b),
    .reg_win   (reg_win),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .cpu_irq   (cpu_irq)
);

// File: tb/irq_router_test.sv
// Self-checking bench: sweeps every pin under two selector programs,
// directed selector write cases and a long pseudo-random phase, all
// compared with a model the bench keeps from its own writes.
module irq_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_a = '0;
    logic [15:0] src_b = '0;
    logic        reg_win = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [4:0]  cpu_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int          sel_m [2][16];
    logic [15:0] msk_m [2];
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    irq_router uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_a     (src_a),
        .src_b     (src_b),
        .reg_win   (reg_win),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cpu_irq   (cpu_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int sel_addr(input int r);
        case (r)
            0: return 'h04;
            1: return 'h06;
            2: return 'h1C;
            default: return 'h1E;
        endcase
    endfunction

    // Pin held in slot k of selector register r, or -1 (R5 layout).
    function automatic int slot_pin(input int r, input int k);
        int t0 [5] = '{0, 1, 2, 3, 8};
        int t1 [5] = '{9, -1, 11, 12, -1};
        int t2 [5] = '{0, 1, 3, 4, 5};
        int t3 [5] = '{6, 7, 8, 9, 10};
        case (r)
            0: return t0[k];
            1: return t1[k];
            2: return t2[k];
            default: return t3[k];
        endcase
    endfunction

    function automatic int exp_sel_reg(input int r);
        int v = 0;
        for (int k = 0; k < 5; k++) begin
            if (slot_pin(r, k) >= 0) v |= sel_m[r / 2][slot_pin(r, k)] << (3 * k);
        end
        return v;
    endfunction

    function automatic bit active(input int g, input int p);
        if (g == 0) return src_a[p] && msk_m[0][p];
        return src_b[p] && msk_m[1][p];
    endfunction

    function automatic int exp_vec(input int o);
        for (int g = 0; g < 2; g++)
            for (int p = 0; p < 16; p++)
                if (active(g, p) && sel_m[g][p] == o) return 32 | (g << 4) | p;
        return 0;
    endfunction

    function automatic int exp_irq();
        int v = 0;
        for (int o = 0; o < 5; o++) if (exp_vec(o) != 0) v |= 1 << o;
        return v;
    endfunction

    function automatic logic [31:0] rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic rd(input logic w, input int a, output logic [15:0] d);
        reg_win  = w;
        reg_addr = 5'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic w, input int a, input logic [15:0] d);
        reg_win   = w;
        reg_addr  = 5'(a);
        reg_wdata = d;
        reg_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        if (!w && a == 'h0C) msk_m[0] = d;
        if (w && a == 'h06)  msk_m[1] = d;
        if (!w) begin
            for (int r = 0; r < 4; r++) begin
                if (a == sel_addr(r)) begin
                    for (int k = 0; k < 5; k++) begin
                        int v = int'((d >> (3 * k)) & 16'h7);
                        if (slot_pin(r, k) >= 0 && v <= 4) sel_m[r / 2][slot_pin(r, k)] = v;
                    end
                end
            end
        end
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_outputs(input string req);
        logic [15:0] d;
        check(req, int'(cpu_irq), exp_irq());
        for (int o = 0; o < 5; o++) begin
            rd(1'b1, 'h10 + 2 * o, d);
            check(req, int'(d), exp_vec(o));
        end
    endtask

    task automatic check_regs(input string req);
        logic [15:0] d;
        rd(1'b0, 'h0C, d); check(req, int'(d), int'(msk_m[0]));
        rd(1'b1, 'h06, d); check(req, int'(d), int'(msk_m[1]));
        for (int r = 0; r < 4; r++) begin
            rd(1'b0, sel_addr(r), d);
            check(req, int'(d), exp_sel_reg(r));
        end
    endtask

    task automatic sweep(input string req);
        for (int g = 0; g < 2; g++) begin
            for (int p = 0; p < 16; p++) begin
                src_a = (g == 0) ? 16'(1 << p) : '0;
                src_b = (g == 1) ? 16'(1 << p) : '0;
                settle();
                check_outputs(req);
            end
        end
    endtask

    initial begin
        logic [15:0] d;
        for (int g = 0; g < 2; g++) begin
            for (int p = 0; p < 16; p++) sel_m[g][p] = 0;
            msk_m[g] = '0;
        end
        sel_m[0][2] = 1;
        sel_m[1][0] = 2;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset images of masks, selectors, lines and vectors
        check_regs("R1");
        check_outputs("R1");
        rd(1'b0, 'h04, d); check("R1", int'(d), 'h0040);
        rd(1'b0, 'h1C, d); check("R1", int'(d), 'h0002);

        // R2: live pending reads, writes to them ignored; R4 masked sources stay quiet
        src_a = 16'hA5C3; src_b = 16'h0F0F;
        rd(1'b0, 'h00, d); check("R2", int'(d), 'hA5C3);
        rd(1'b1, 'h00, d); check("R2", int'(d), 'h0F0F);
        settle();
        check("R4", int'(cpu_irq), 0);
        wr(1'b0, 'h00, 16'h1234);
        wr(1'b1, 'h00, 16'h4321);
        src_a = 16'hFFFF; src_b = 16'h8000;
        rd(1'b0, 'h00, d); check("R2", int'(d), 'hFFFF);
        rd(1'b1, 'h00, d); check("R2", int'(d), 'h8000);
        check_regs("R2");

        // R3: mask read/write
        wr(1'b0, 'h0C, 16'h5A3C);
        wr(1'b1, 'h06, 16'hC3A5);
        check_regs("R3");
        wr(1'b0, 'h0C, 16'hFFFF);
        wr(1'b1, 'h06, 16'hFFFF);
        check_regs("R3");

        // R8: default routing, one pin at a time
        sweep("R8");

        // R4: one-edge latency, level hold, mask removal
        src_a = '0; src_b = '0;
        settle();
        src_a = 16'h0020;
        #1 check("R4", int'(cpu_irq), 0);
        settle();
        check("R4", int'(cpu_irq), 1);
        repeat (3) settle();
        check("R4", int'(cpu_irq), 1);
        wr(1'b0, 'h0C, 16'hFFDF);
        check("R4", int'(cpu_irq), 1);
        settle();
        check("R4", int'(cpu_irq), 0);
        check_outputs("R4");
        wr(1'b0, 'h0C, 16'hFFFF);
        settle();
        check("R4", int'(cpu_irq), 1);
        src_a = '0;
        settle();
        check("R4", int'(cpu_irq), 0);

        // R5: program every selector field, read back and sweep
        for (int r = 0; r < 4; r++) begin
            logic [15:0] v = '0;
            for (int k = 0; k < 5; k++) v |= 16'(((r + k + 1) % 5) << (3 * k));
            wr(1'b0, sel_addr(r), v);
        end
        check_regs("R5");
        sweep("R5");

        // R6: oversized fields dropped, legal ones in the same write land
        wr(1'b0, 'h04, 16'(7 | (2 << 3) | (5 << 6) | (4 << 9) | (6 << 12)));
        check_regs("R6");
        for (int r = 0; r < 4; r++) wr(1'b0, sel_addr(r), 16'h7FFF);
        check_regs("R6");
        wr(1'b0, 'h1E, 16'(0 | (1 << 3) | (7 << 6) | (3 << 9) | (0 << 12)));
        check_regs("R6");

        // R7: reserved bits ignored, unmapped pins fixed on line 0
        wr(1'b0, 'h06, 16'hFFFF);
        check_regs("R7");
        wr(1'b0, 'h06, 16'(16'hF000 | 1 | (3 << 3) | (4 << 6) | (2 << 9)));
        rd(1'b0, 'h06, d); check("R7", int'(d), 1 | (4 << 6) | (2 << 9));
        wr(1'b0, 'h1C, 16'(16'h8000 | 3 | (4 << 12)));
        rd(1'b0, 'h1C, d); check("R7", int'(d), exp_sel_reg(2));
        check("R7", int'(d[15]), 0);
        sweep("R7");

        // R9: random sources, masks and selectors; fixed-order winner
        for (int i = 0; i < 300; i++) begin
            if (i % 25 == 0) wr(1'b0, sel_addr((i / 25) % 4), 16'(rnd()));
            if (i % 10 == 0) begin
                wr(1'b0, 'h0C, 16'(rnd()));
                wr(1'b1, 'h06, 16'(rnd()));
            end
            src_a = (i % 7 == 0) ? '0 : 16'(rnd());
            src_b = (i % 11 == 0) ? '0 : 16'(rnd() & rnd());
            settle();
            check_outputs("R9");
        end
        src_a = '0; src_b = '0;
        settle();
        check_outputs("R9");

        // R10: unmapped offsets and vector writes have no effect
        wr(1'b0, 'h0C, 16'hFFFF);
        wr(1'b1, 'h06, 16'hFFFF);
        src_a = 16'h0104; src_b = 16'h0003;
        wr(1'b0, 'h08, 16'hFFFF);
        wr(1'b0, 'h05, 16'hFFFF);
        wr(1'b1, 'h02, 16'hFFFF);
        wr(1'b1, 'h10, 16'hFFFF);
        wr(1'b1, 'h0C, 16'h0000);
        rd(1'b0, 'h08, d); check("R10", int'(d), 0);
        rd(1'b0, 'h05, d); check("R10", int'(d), 0);
        rd(1'b1, 'h02, d); check("R10", int'(d), 0);
        rd(1'b1, 'h0C, d); check("R10", int'(d), 0);
        check_regs("R10");
        check_outputs("R10");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule